// File: doc/BRIEF.md
# Half-Integer Clock Pre-Divider

This block produces a divided clock and a matching one-cycle enable from a reference clock that runs at twice the rate of the selected source. A divider field `h` sets the output rate to source × 2 / (h + 1). Because the logic runs on the double-rate reference, ratios such as 1.5 and 2.5 are plain integer counts of reference cycles. An output period is therefore h + 1 reference cycles. A field of zero means bypass: the output then runs at the source rate, which is two reference cycles per period.

Downstream logic can use `div_clk_o` as a near-even-duty divided clock. It can also use `div_en_o` as a clock enable in the reference domain. A new field value is held back until the current output period has ended, so a change never produces a short pulse. Only the low `DIV_W` bits of the incoming configuration field are used.

Top module: `half_div`

## Requirements
- R1: For a masked field value h from 1 to 2^DIV_W−1, each output period, measured from one `div_en_o` pulse to the next, lasts exactly h + 1 reference cycles.
- R2: A masked field value of 0 is bypass: each output period lasts 2 reference cycles, and `div_clk_o` is high for 1 of them.
- R3: A field of 1 gives a period of 2 reference cycles (divide-by-1 of the source). A field of 3 gives a period of 4 reference cycles (divide-by-2 of the source).
- R4: Within each period of P reference cycles, `div_clk_o` is high for the first floor(P/2) cycles and low for the rest. `div_en_o` is asserted only in the first high cycle.
- R5: `div_en_o` is high for exactly one reference cycle per output period.
- R6: Bits of `div_cfg_i` at or above position DIV_W are ignored. For example, with DIV_W=4, field 0x23 behaves as 3 and field 0x30 behaves as 0.
- R7: A change of `div_cfg_i` does not alter the period in progress. The new value takes effect from the next period start.
- R8: While `rst_ni` is low, `div_clk_o` and `div_en_o` are low. After release, the first `div_en_o` appears on the second rising reference edge, and the period it opens already uses the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the source rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_cfg_i | input | CFG_W | Divider field from the active configuration; low DIV_W bits used |
| div_clk_o | output | 1 | Divided clock, near-even duty |
| div_en_o | output | 1 | One-cycle enable at the start of each output period |

## Verification
The hardest case to reach from the ports is a field change that lands inside a long period. It has to be shown that the change neither cuts that period short nor stretches it. The stimulus first lines up on an enable pulse with a long ratio in force. It then switches to a short ratio on the very next cycle, and measures both the period still in progress and the one that follows. A full sweep of every field value, wider fields carrying set upper bits, and a field set while reset is held complete the coverage.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  // period in reference cycles for a masked field value
  function automatic int unsigned period_of(input int unsigned h);
    return (h == 0) ? 2 : h + 1;
  endfunction
endpackage

// File: rtl/hdiv_period.sv
module hdiv_period #(
  parameter int unsigned CFG_W = 6,
  parameter int unsigned DIV_W = 4,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic [CFG_W-1:0] field_i,
  output logic [CNT_W-1:0] period_o
);
  logic [DIV_W-1:0] h;

  generate
    if (CFG_W >= DIV_W) begin : g_mask
      assign h = field_i[DIV_W-1:0];
    end else begin : g_pad
      assign h = DIV_W'(field_i);
    end
  endgenerate

  // zero selects bypass: source rate, two reference cycles
  assign period_o = (h == '0) ? CNT_W'(2) : CNT_W'(h) + CNT_W'(1);
endmodule

// File: rtl/hdiv_counter.sv
module hdiv_counter #(
  parameter int unsigned DIV_W = 4,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic [CNT_W-1:0] per_next_o
);
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             wrap;

  assign wrap       = (cnt_q == per_q - CNT_W'(1));
  assign cnt_next_o = wrap ? '0 : cnt_q + CNT_W'(1);
  // new ratio sampled only at period end
  assign per_next_o = wrap ? period_i : per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= CNT_W'(2);
    end else begin
      cnt_q <= cnt_next_o;
      per_q <= per_next_o;
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);
  // R1
  per_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q >= CNT_W'(2)) && (per_q <= CNT_W'(1 << DIV_W)));
  // R7
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(per_q));
endmodule

// File: rtl/hdiv_wave.sv
module hdiv_wave #(
  parameter int unsigned DIV_W = 4,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic [CNT_W-1:0] per_next_i,
  output logic             div_clk_o,
  output logic             div_en_o
);
  logic clk_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      clk_q <= cnt_next_i < (per_next_i >> 1);
      en_q  <= cnt_next_i == '0;
    end
  end

  assign div_clk_o = clk_q;
  assign div_en_o  = en_q;

  // R4
  en_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |-> div_clk_o);
  // R5
  en_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |=> !div_en_o);

  // R8
  always_comb begin
    if (!rst_ni) begin
      reset_low_chk: assert (!clk_q && !en_q);
    end
  end
endmodule

// File: rtl/half_div.sv
module half_div #(
  parameter int unsigned CFG_W = 6,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] div_cfg_i,
  output logic             div_clk_o,
  output logic             div_en_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] period, cnt_next, per_next;

  hdiv_period #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_period (
    .field_i  (div_cfg_i),
    .period_o (period)
  );

  hdiv_counter #(.DIV_W(DIV_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .period_i   (period),
    .cnt_next_o (cnt_next),
    .per_next_o (per_next)
  );

  hdiv_wave #(.DIV_W(DIV_W)) u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_next_i (cnt_next),
    .per_next_i (per_next),
    .div_clk_o  (div_clk_o),
    .div_en_o   (div_en_o)
  );
endmodule

// File: tb/half_div_bench.sv
module half_div_bench;
  localparam int unsigned CFG_W = 6;
  localparam int unsigned DIV_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CFG_W-1:0] div_cfg_i = '0;
  logic             div_clk_o, div_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  half_div #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_half_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_cfg_i(div_cfg_i),
    .div_clk_o(div_clk_o), .div_en_o(div_en_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_en(input string req);
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_en_o && n < 200);
    if (!div_en_o) check(req, 0, 1);
  endtask

  // starts at an enable sample, ends at the next one
  task automatic measure(output int len, output int hi);
    len = 1;
    hi  = int'(div_clk_o);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (div_en_o) break;
      len++;
      hi += int'(div_clk_o);
    end
  endtask

  function automatic int exp_per(input int h);
    int m = h % (1 << DIV_W);
    return (m == 0) ? 2 : m + 1;
  endfunction

  initial begin
    int len, hi;
    // R8 reset holds outputs low
    div_cfg_i = 6'd5;
    repeat (3) @(negedge clk_i);
    check("R8 clk in reset", int'(div_clk_o), 0);
    check("R8 en in reset", int'(div_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 no en at first edge", int'(div_en_o), 0);
    @(negedge clk_i);
    check("R8 en at second edge", int'(div_en_o), 1);
    measure(len, hi);
    check("R8 first period uses field", len, 6);

    // R1 R2 R3 R4 R5 sweep of every field value
    for (int h = 0; h < (1 << DIV_W); h++) begin
      div_cfg_i = CFG_W'(h);
      wait_en("R1 sync");
      wait_en("R1 sync");
      for (int k = 0; k < 2; k++) begin
        measure(len, hi);
        if (h == 0) check("R2 bypass period", len, 2);
        else if (h == 1 || h == 3) check("R3 period", len, exp_per(h));
        else check("R1 period", len, exp_per(h));
        check("R4 high time", hi, exp_per(h) / 2);
      end
    end

    // R6 upper bits ignored
    div_cfg_i = 6'h23;
    wait_en("R6 sync");
    wait_en("R6 sync");
    measure(len, hi);
    check("R6 field 0x23 period", len, 4);
    div_cfg_i = 6'h30;
    wait_en("R6 sync");
    wait_en("R6 sync");
    measure(len, hi);
    check("R6 field 0x30 period", len, 2);
    check("R6 field 0x30 high", hi, 1);

    // R7 change lands inside a long period
    div_cfg_i = 6'd9;
    wait_en("R7 sync");
    wait_en("R7 sync");
    measure(len, hi);
    check("R7 long period", len, 10);
    div_cfg_i = 6'd4;
    @(negedge clk_i);
    len = 2;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (div_en_o) break;
      len++;
    end
    check("R7 period in progress kept", len, 10);
    measure(len, hi);
    check("R7 new period", len, 5);
    check("R4 new high", hi, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule